// File: doc/BRIEF.md
# Scale and Rotate Parameter Checker

This block screens a scale-and-rotate job configuration before any pixel moves. A one-cycle start strobe samples the source picture size, the source block size and offset, the destination picture size and offset, two fixed-point scale factors, a rotation code and two YUV420 flags. A small state machine then derives the scaled block size along each axis with one shared multiplier and evaluates every legality rule.

When it finishes, the block presents a 14-bit error vector for one result. It also gives a one-cycle pulse: an error interrupt if any rule failed, or a go strobe if the job may run. The error vector holds its value until the next accepted start produces a new result. A job controller uses the go strobe to launch the datapath. It uses the interrupt together with the vector to report a bad configuration.

Top module: `sr_param_check`

## Requirements
- R1: Each scale factor is an 8-bit integer part plus a 4-bit fraction in sixteenths. The scaled width is floor(src_blk_w * (16*int + frac) / 16), and the scaled height is formed the same way from src_blk_h and the Y factor.
- R2: A scale factor whose integer and fraction are both zero sets err_o[0] (X) or err_o[1] (Y).
- R3: A scaled width of zero sets err_o[2]. A scaled height of zero sets err_o[3]. Example: a block of 14 at scale 1/16 gives 0.
- R4: A scaled width above 8191 sets err_o[4]. A scaled height above 8191 sets err_o[5]. A value of exactly 8191 is legal.
- R5: src_blk_w + src_off_x > src_area_w sets err_o[6]. src_blk_h + src_off_y > src_area_h sets err_o[7]. Equality is legal.
- R6: The destination block is the scaled size, with width and height swapped for rotation codes 1 (90°) and 3 (270°) and unswapped for 0 (0°) and 2 (180°). Destination block width + dst_off_x > dst_area_w sets err_o[8]. The same test in Y sets err_o[9].
- R7: With yuv_in_i high, an odd src_area_w, src_blk_w or src_off_x sets err_o[10]. An odd value among the matching Y terms sets err_o[11].
- R8: With yuv_out_i high, an odd dst_area_w, destination block width or dst_off_x sets err_o[12]. An odd value among the Y terms sets err_o[13].
- R9: done_o is high for exactly one cycle, during the fourth cycle after the edge that samples start_i. err_o takes its new value in that same cycle and then holds until the next result, whatever the inputs do.
- R10: In the done cycle, err_irq_o is high if err_o is nonzero and go_o is high otherwise. The two are never high together and are low outside the done cycle.
- R11: start_i is ignored while busy_o is high. The result reflects the configuration sampled by the accepted start, and only one done pulse occurs.
- R12: After reset, err_o is zero and busy_o, done_o, go_o and err_irq_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; samples all configuration inputs |
| src_area_w_i | input | 14 | Source picture width |
| src_area_h_i | input | 14 | Source picture height |
| src_blk_w_i | input | 14 | Source block width |
| src_blk_h_i | input | 14 | Source block height |
| src_off_x_i | input | 14 | Source block X offset |
| src_off_y_i | input | 14 | Source block Y offset |
| dst_area_w_i | input | 14 | Destination picture width |
| dst_area_h_i | input | 14 | Destination picture height |
| dst_off_x_i | input | 14 | Destination block X offset |
| dst_off_y_i | input | 14 | Destination block Y offset |
| scale_x_int_i | input | 8 | X scale integer part |
| scale_x_frac_i | input | 4 | X scale fraction, sixteenths |
| scale_y_int_i | input | 8 | Y scale integer part |
| scale_y_frac_i | input | 4 | Y scale fraction, sixteenths |
| rot_i | input | 2 | Rotation code: 0, 90, 180, 270 degrees |
| yuv_in_i | input | 1 | Source is YUV420 |
| yuv_out_i | input | 1 | Destination is YUV420 |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle result strobe |
| go_o | output | 1 | One-cycle pulse: configuration legal |
| err_irq_o | output | 1 | One-cycle pulse: any rule failed |
| err_o | output | 14 | Error vector of the last result |

## Verification
The hardest cases to reach are those where the rotation swap alone decides the destination bound. A job that is legal at 90° must fail at 0° purely because the scaled width lands on the wrong axis. The stimulus uses a non-square block against a non-square destination and sweeps all four rotation codes with everything else fixed. The size-limit boundaries are reached with a source block of 4096 at scale 2.0 (one past the limit) and 8191 at scale 1.0 (exactly on it). A second start during the compute phase, carrying a clean configuration, shows that the first sampled job alone is reported.

// File: rtl/sr_chk_pkg.sv
package sr_chk_pkg;
  localparam int ERR_W       = 14;
  // bit base per rule; +0 is X axis, +1 is Y axis
  localparam int E_SCALE_ZERO = 0;
  localparam int E_DST_ZERO   = 2;
  localparam int E_DST_BIG    = 4;
  localparam int E_SRC_OOB    = 6;
  localparam int E_DST_OOB    = 8;
  localparam int E_YUV_IN     = 10;
  localparam int E_YUV_OUT    = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_COMPUTE, ST_CHECK, ST_DONE} chk_st_e;
  typedef enum logic [1:0] {ROT_0, ROT_90, ROT_180, ROT_270} rot_e;
endpackage

// File: rtl/sr_scale_mul.sv
module sr_scale_mul #(
  parameter int DIM_W  = 14,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  localparam int SC_W  = DIM_W + INT_W
) (
  input  logic [DIM_W-1:0]  len_i,
  input  logic [INT_W-1:0]  sc_int_i,
  input  logic [FRAC_W-1:0] sc_frac_i,
  output logic [SC_W-1:0]   scaled_o
);
  localparam int PROD_W = DIM_W + INT_W + FRAC_W;
  logic [PROD_W-1:0] prod;

  always_comb begin
    prod     = PROD_W'(len_i) * PROD_W'({sc_int_i, sc_frac_i});
    scaled_o = prod[PROD_W-1:FRAC_W]; // floor
  end
endmodule

// File: rtl/sr_rule_eval.sv
module sr_rule_eval
  import sr_chk_pkg::*;
#(
  parameter int DIM_W   = 14,
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 4,
  parameter int MAX_DST = 8191,
  localparam int SC_W   = DIM_W + INT_W
) (
  input  logic [1:0][DIM_W-1:0]  src_area_i,
  input  logic [1:0][DIM_W-1:0]  src_blk_i,
  input  logic [1:0][DIM_W-1:0]  src_off_i,
  input  logic [1:0][DIM_W-1:0]  dst_area_i,
  input  logic [1:0][DIM_W-1:0]  dst_off_i,
  input  logic [1:0][INT_W-1:0]  sc_int_i,
  input  logic [1:0][FRAC_W-1:0] sc_frac_i,
  input  logic [1:0][SC_W-1:0]   scaled_i,
  input  rot_e                   rot_i,
  input  logic                   yuv_in_i,
  input  logic                   yuv_out_i,
  output logic [ERR_W-1:0]       err_o
);
  logic              swap;
  logic [1:0][SC_W-1:0] dst_blk;

  always_comb begin
    swap       = (rot_i == ROT_90) || (rot_i == ROT_270);
    dst_blk[0] = swap ? scaled_i[1] : scaled_i[0];
    dst_blk[1] = swap ? scaled_i[0] : scaled_i[1];
  end

  for (genvar g = 0; g < 2; g++) begin : g_axis
    logic [DIM_W:0] src_end;
    logic [SC_W:0]  dst_end;
    always_comb begin
      src_end = {1'b0, src_blk_i[g]} + {1'b0, src_off_i[g]};
      dst_end = {1'b0, dst_blk[g]} + (SC_W+1)'(dst_off_i[g]);
      err_o[E_SCALE_ZERO+g] = ({sc_int_i[g], sc_frac_i[g]} == '0);
      err_o[E_DST_ZERO+g]   = (scaled_i[g] == '0);
      err_o[E_DST_BIG+g]    = (scaled_i[g] > SC_W'(MAX_DST));
      err_o[E_SRC_OOB+g]    = (src_end > {1'b0, src_area_i[g]});
      err_o[E_DST_OOB+g]    = (dst_end > (SC_W+1)'(dst_area_i[g]));
      err_o[E_YUV_IN+g]     = yuv_in_i &
                              (src_area_i[g][0] | src_blk_i[g][0] | src_off_i[g][0]);
      err_o[E_YUV_OUT+g]    = yuv_out_i &
                              (dst_area_i[g][0] | dst_blk[g][0] | dst_off_i[g][0]);
    end
  end
endmodule

// File: rtl/sr_param_check.sv
module sr_param_check
  import sr_chk_pkg::*;
#(
  parameter int DIM_W   = 14,
  parameter int INT_W   = 8,
  parameter int FRAC_W  = 4,
  parameter int MAX_DST = 8191
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  src_area_w_i,
  input  logic [DIM_W-1:0]  src_area_h_i,
  input  logic [DIM_W-1:0]  src_blk_w_i,
  input  logic [DIM_W-1:0]  src_blk_h_i,
  input  logic [DIM_W-1:0]  src_off_x_i,
  input  logic [DIM_W-1:0]  src_off_y_i,
  input  logic [DIM_W-1:0]  dst_area_w_i,
  input  logic [DIM_W-1:0]  dst_area_h_i,
  input  logic [DIM_W-1:0]  dst_off_x_i,
  input  logic [DIM_W-1:0]  dst_off_y_i,
  input  logic [INT_W-1:0]  scale_x_int_i,
  input  logic [FRAC_W-1:0] scale_x_frac_i,
  input  logic [INT_W-1:0]  scale_y_int_i,
  input  logic [FRAC_W-1:0] scale_y_frac_i,
  input  logic [1:0]        rot_i,
  input  logic              yuv_in_i,
  input  logic              yuv_out_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              go_o,
  output logic              err_irq_o,
  output logic [ERR_W-1:0]  err_o
);
  localparam int SC_W = DIM_W + INT_W;

  chk_st_e state_q;
  logic    phase_q;
  logic [1:0][DIM_W-1:0]  src_area_q, src_blk_q, src_off_q, dst_area_q, dst_off_q;
  logic [1:0][INT_W-1:0]  sc_int_q;
  logic [1:0][FRAC_W-1:0] sc_frac_q;
  rot_e                   rot_q;
  logic                   yuv_in_q, yuv_out_q;
  logic [1:0][SC_W-1:0]   scaled_q;
  logic [SC_W-1:0]        mul_out;
  logic [ERR_W-1:0]       err_c, err_q;

  // one multiplier shared by both axes, axis picked by phase
  sr_scale_mul #(.DIM_W(DIM_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_mul (
    .len_i    (src_blk_q[phase_q]),
    .sc_int_i (sc_int_q[phase_q]),
    .sc_frac_i(sc_frac_q[phase_q]),
    .scaled_o (mul_out)
  );

  sr_rule_eval #(.DIM_W(DIM_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .MAX_DST(MAX_DST)) u_rules (
    .src_area_i(src_area_q),
    .src_blk_i (src_blk_q),
    .src_off_i (src_off_q),
    .dst_area_i(dst_area_q),
    .dst_off_i (dst_off_q),
    .sc_int_i  (sc_int_q),
    .sc_frac_i (sc_frac_q),
    .scaled_i  (scaled_q),
    .rot_i     (rot_q),
    .yuv_in_i  (yuv_in_q),
    .yuv_out_i (yuv_out_q),
    .err_o     (err_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= 1'b0;
      src_area_q <= '0;
      src_blk_q  <= '0;
      src_off_q  <= '0;
      dst_area_q <= '0;
      dst_off_q  <= '0;
      sc_int_q   <= {INT_W'(1), INT_W'(1)};
      sc_frac_q  <= '0;
      rot_q      <= ROT_0;
      yuv_in_q   <= 1'b0;
      yuv_out_q  <= 1'b0;
      scaled_q   <= '0;
      err_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          src_area_q <= {src_area_h_i, src_area_w_i};
          src_blk_q  <= {src_blk_h_i, src_blk_w_i};
          src_off_q  <= {src_off_y_i, src_off_x_i};
          dst_area_q <= {dst_area_h_i, dst_area_w_i};
          dst_off_q  <= {dst_off_y_i, dst_off_x_i};
          sc_int_q   <= {scale_y_int_i, scale_x_int_i};
          sc_frac_q  <= {scale_y_frac_i, scale_x_frac_i};
          rot_q      <= rot_e'(rot_i);
          yuv_in_q   <= yuv_in_i;
          yuv_out_q  <= yuv_out_i;
          phase_q    <= 1'b0;
          state_q    <= ST_COMPUTE;
        end
        ST_COMPUTE: begin
          scaled_q[phase_q] <= mul_out;
          phase_q           <= 1'b1;
          if (phase_q) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          err_q   <= err_c;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o    = (state_q != ST_IDLE);
    done_o    = (state_q == ST_DONE);
    err_irq_o = done_o && (err_q != '0);
    go_o      = done_o && (err_q == '0);
    err_o     = err_q;
  end

  AST_IRQ_GO_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_irq_o && go_o)); // R10
  AST_PULSE_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_o || go_o) |-> done_o); // R10
  AST_DONE_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_CHECK) |=> $stable(err_o)); // R9
  AST_SCALE_ZERO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o[E_SCALE_ZERO]) |-> err_o[E_DST_ZERO]); // R2
  AST_BUSY_HOLDS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMPUTE) |=> $stable(src_blk_q)); // R11
endmodule

// File: tb/tb_sr_param_check.sv
module tb_sr_param_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [13:0] src_area_w_i, src_area_h_i, src_blk_w_i, src_blk_h_i, src_off_x_i, src_off_y_i;
  logic [13:0] dst_area_w_i, dst_area_h_i, dst_off_x_i, dst_off_y_i;
  logic [7:0]  scale_x_int_i, scale_y_int_i;
  logic [3:0]  scale_x_frac_i, scale_y_frac_i;
  logic [1:0]  rot_i;
  logic        yuv_in_i, yuv_out_i;
  logic        busy_o, done_o, go_o, err_irq_o;
  logic [13:0] err_o;

  int checks = 0;
  int errors = 0;
  logic [13:0] res_err;
  logic        res_go, res_irq;
  int          res_lat, res_dones;

  sr_param_check dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_default();
    src_area_w_i = 64; src_area_h_i = 64; src_blk_w_i = 16; src_blk_h_i = 16;
    src_off_x_i = 0; src_off_y_i = 0;
    dst_area_w_i = 64; dst_area_h_i = 64; dst_off_x_i = 0; dst_off_y_i = 0;
    scale_x_int_i = 1; scale_x_frac_i = 0; scale_y_int_i = 1; scale_y_frac_i = 0;
    rot_i = 0; yuv_in_i = 0; yuv_out_i = 0;
  endtask

  // pulse start, then watch 10 cycles for the result
  task automatic run_job();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    res_lat = -1; res_dones = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (done_o) begin
        res_dones++;
        if (res_lat < 0) begin
          res_lat = i; res_err = err_o; res_go = go_o; res_irq = err_irq_o;
        end
      end else begin
        if (go_o || err_irq_o) check("R10 pulse outside done", 1, 0);
      end
    end
  endtask

  task automatic expect_job(input string req, input int exp_err);
    run_job();
    check({req, " err"}, res_err, exp_err);
    check({req, " latency R9"}, res_lat, 2);
    check({req, " go R10"}, res_go, (exp_err == 0));
    check({req, " irq R10"}, res_irq, (exp_err != 0));
  endtask

  task automatic t_reset();
    check("R12 err", err_o, 0);
    check("R12 flags", {busy_o, done_o, go_o, err_irq_o}, 0);
  endtask

  task automatic t_clean();
    set_default(); expect_job("R1 clean", 14'h0000);
    check("R9 single done", res_dones, 1);
    scale_x_int_i = 1; scale_x_frac_i = 8; src_blk_w_i = 40; dst_area_w_i = 60;
    expect_job("R1 1.5x fits", 14'h0000);          // 60 <= 60
    dst_area_w_i = 59; expect_job("R1 1.5x over", 14'h0100);
  endtask

  task automatic t_scale_zero();
    set_default(); scale_x_int_i = 0; expect_job("R2 x zero", 14'h0005);
    set_default(); scale_y_int_i = 0; expect_job("R2 y zero", 14'h000A);
  endtask

  task automatic t_floor_zero();
    set_default(); scale_x_int_i = 0; scale_x_frac_i = 1; src_blk_w_i = 14;
    expect_job("R3 w floors to 0", 14'h0004);
    src_blk_w_i = 16; expect_job("R3 w floors to 1", 14'h0000);
    set_default(); scale_y_int_i = 0; scale_y_frac_i = 1; src_blk_h_i = 15;
    expect_job("R3 h floors to 0", 14'h0008);
  endtask

  task automatic t_too_big();
    set_default(); src_area_w_i = 4096; src_blk_w_i = 4096; scale_x_int_i = 2;
    dst_area_w_i = 8191; expect_job("R4 w 8192", 14'h0110);
    scale_x_int_i = 1; scale_x_frac_i = 15; expect_job("R4 w 7936", 14'h0000);
    set_default(); src_area_h_i = 8191; src_blk_h_i = 8191; dst_area_h_i = 8191;
    expect_job("R4 h 8191 legal", 14'h0000);
    scale_y_frac_i = 1; expect_job("R4 h over", 14'h0220);
  endtask

  task automatic t_src_bounds();
    set_default(); src_off_x_i = 48; expect_job("R5 x equal", 14'h0000);
    src_off_x_i = 49; expect_job("R5 x over", 14'h0040);
    set_default(); src_off_y_i = 49; expect_job("R5 y over", 14'h0080);
  endtask

  task automatic t_rotation();
    set_default(); src_blk_w_i = 32; src_blk_h_i = 16; dst_area_w_i = 20; dst_area_h_i = 40;
    rot_i = 0; expect_job("R6 rot0", 14'h0100);
    rot_i = 1; expect_job("R6 rot90", 14'h0000);
    rot_i = 2; expect_job("R6 rot180", 14'h0100);
    rot_i = 3; expect_job("R6 rot270", 14'h0000);
    set_default(); dst_off_y_i = 49; expect_job("R6 y over", 14'h0200);
  endtask

  task automatic t_yuv_in();
    set_default(); src_off_x_i = 1; expect_job("R7 yuv off", 14'h0000);
    yuv_in_i = 1; expect_job("R7 x odd", 14'h0400);
    set_default(); yuv_in_i = 1; src_blk_h_i = 15; expect_job("R7 y odd", 14'h0800);
  endtask

  task automatic t_yuv_out();
    set_default(); yuv_out_i = 1; dst_off_x_i = 3; expect_job("R8 x odd", 14'h1000);
    set_default(); yuv_out_i = 1; src_blk_h_i = 18; scale_y_int_i = 0; scale_y_frac_i = 8;
    expect_job("R8 scaled h odd", 14'h2000);      // 18 * 0.5 = 9
    yuv_out_i = 0; expect_job("R8 yuv off", 14'h0000);
  endtask

  task automatic t_busy_start();
    set_default(); scale_x_int_i = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) begin start_i = 1'b1; set_default(); end
    @(negedge clk_i) start_i = 1'b0;
    res_dones = 0; res_err = '0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (done_o) begin res_dones++; if (res_dones == 1) res_err = err_o; end
    end
    check("R11 first cfg kept", res_err, 14'h0005);
    check("R11 one done", res_dones, 1);
  endtask

  task automatic t_hold();
    set_default(); src_off_x_i = 49; run_job();
    set_default(); scale_y_int_i = 0; yuv_in_i = 1; src_off_y_i = 3;
    repeat (6) @(negedge clk_i);
    check("R9 err held", err_o, 14'h0040);
    check("R9 no done without start", done_o, 0);
  endtask

  initial begin
    set_default();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_clean();
    t_scale_zero();
    t_floor_zero();
    t_too_big();
    t_src_bounds();
    t_rotation();
    t_yuv_in();
    t_yuv_out();
    t_busy_start();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200us;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule